// File: doc/BRIEF.md
# Scalable System Counter

A 64-bit system count generator that advances on each reference tick and drives its value to downstream timers. A 32-bit register port gives software control over the count. Software can start and stop counting, switch between whole-unit stepping and scaled stepping, read the count as two 32-bit words, and overwrite either word.

In scaled mode each tick adds a programmable fixed-point increment, so the visible count rate can be divided by a non-integer factor. The increment has 8 integer bits and 24 fraction bits. The fraction is kept in a hidden accumulator below the visible count. When that accumulator overflows, it carries into the integer count. Any software write to the count clears the accumulator, so the count restarts from a clean whole value.

The register port is a single-cycle interface. A write takes effect at the clock edge where `req_i` and `we_i` are both high. Read data is combinational and is driven only while `req_i` is high and `we_i` is low.

Top module: `scaled_sys_counter`

## Requirements
- R1: After reset the count is 0 and control reads 0. Status reads 1 and the scale register reads 0x01000000 (one unit per tick).
- R2: While control bit 0 (enable) is clear, the count does not change, whatever `tick_i` does.
- R3: With enable set and control bit 2 clear, the count rises by exactly 1 at every clock edge where `tick_i` is high. Edges where `tick_i` is low add nothing.
- R4: Control is at offset 0x0. Only bit 0 (enable) and bit 2 (scale enable) are stored, and all other bits read as 0. Writing 5 sets both stored bits.
- R5: The scale register is at offset 0x10, with bits 31:24 integer and bits 23:0 fraction. With scaling on, each tick adds the scale value to a 24-bit fraction accumulator plus the count, carrying on overflow. For example, 0x00100000 for 160 ticks adds 10, and 0x01800000 for 4 ticks adds 6.
- R6: Offset 0x8 writes the count bits 31:0 and offset 0xC writes bits 63:32. The other word is kept. A write takes precedence over a tick in the same cycle. A write also clears the fraction accumulator.
- R7: Status is at offset 0x4. Bit 0 reads 1 while enable is clear and 0 while it is set, and all other bits read 0.
- R8: Offsets other than 0x0, 0x4, 0x8, 0xC and 0x10 (including unaligned ones) read as 0. Writes to them change neither the registers nor the count.
- R9: `count_o` always carries the full 64-bit count. An increment out of bit 31 propagates into bit 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Byte offset in the control frame |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| tick_i | input | 1 | Reference tick enable |
| count_o | output | 64 | Current system count |

## Verification
The bench aims at the fractional path:
- It runs 160 ticks at 1/16 scale. A design that dropped the carry would show no progress, and one that truncated the fraction incorrectly would show an off-by-one.
- It stops midway with half a unit pending, writes the count, and ticks again. A design that kept the accumulator across the write would step one early.
- It uses a 1.5 scale. A design that ignored the integer byte of the scale would under-count.

It also checks these corners:
- A write and a tick in the same cycle, where a wrongly ordered update leaves the written value plus one.
- The carry from the low word into the high word.
- Masking of control bits and undefined offsets, where a sloppy decoder would alias registers or corrupt state.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL,
    SEL_STAT,
    SEL_CLO,
    SEL_CHI,
    SEL_SCALE,
    SEL_NONE
  } reg_sel_e;

  localparam int unsigned OFF_CTRL  = 'h00;
  localparam int unsigned OFF_STAT  = 'h04;
  localparam int unsigned OFF_CLO   = 'h08;
  localparam int unsigned OFF_CHI   = 'h0C;
  localparam int unsigned OFF_SCALE = 'h10;

  localparam int unsigned CTRL_EN_BIT = 0;
  localparam int unsigned CTRL_SC_BIT = 2;
endpackage

// File: rtl/ssc_regs.sv
module ssc_regs
  import ssc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned FRAC_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              en_o,
  output logic              scale_en_o,
  output logic [DATA_W-1:0] scale_o,
  output logic [CNT_W/DATA_W-1:0] cnt_wr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned NWORDS = CNT_W / DATA_W;
  localparam logic [DATA_W-1:0] SCALE_ONE = DATA_W'(1) << FRAC_W;

  reg_sel_e          sel;
  logic              wr, rd;
  logic              en_q, sc_q;
  logic [DATA_W-1:0] scale_q;

  always_comb begin
    unique case (addr_i)
      ADDR_W'(OFF_CTRL):  sel = SEL_CTRL;
      ADDR_W'(OFF_STAT):  sel = SEL_STAT;
      ADDR_W'(OFF_CLO):   sel = SEL_CLO;
      ADDR_W'(OFF_CHI):   sel = SEL_CHI;
      ADDR_W'(OFF_SCALE): sel = SEL_SCALE;
      default:            sel = SEL_NONE;
    endcase
  end

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      sc_q    <= 1'b0;
      scale_q <= SCALE_ONE;
    end else if (wr) begin
      if (sel == SEL_CTRL) begin
        en_q <= wdata_i[CTRL_EN_BIT];
        sc_q <= wdata_i[CTRL_SC_BIT];
      end
      if (sel == SEL_SCALE) scale_q <= wdata_i;
    end
  end

  always_comb begin
    cnt_wr_o = '0;
    if (wr && sel == SEL_CLO) cnt_wr_o[0] = 1'b1;
    if (wr && sel == SEL_CHI) cnt_wr_o[NWORDS-1] = 1'b1;
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (sel)
        SEL_CTRL: begin
          rdata_o[CTRL_EN_BIT] = en_q;
          rdata_o[CTRL_SC_BIT] = sc_q;
        end
        SEL_STAT:  rdata_o[0] = ~en_q;
        SEL_CLO:   rdata_o = count_i[DATA_W-1:0];
        SEL_CHI:   rdata_o = count_i[CNT_W-1 -: DATA_W];
        SEL_SCALE: rdata_o = scale_q;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign en_o       = en_q;
  assign scale_en_o = sc_q;
  assign scale_o    = scale_q;

  p_undef_rd_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && sel == SEL_NONE) |-> rdata_o == '0);
  p_undef_wr_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel == SEL_NONE) |=> ($stable(en_q) && $stable(sc_q) && $stable(scale_q)));
  p_status_halted_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && sel == SEL_STAT) |-> (rdata_o[0] == !en_o && rdata_o[DATA_W-1:1] == '0));
endmodule

// File: rtl/ssc_core.sv
module ssc_core #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned FRAC_W = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic                    en_i,
  input  logic                    scale_en_i,
  input  logic [DATA_W-1:0]       scale_i,
  input  logic [CNT_W/DATA_W-1:0] cnt_wr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [CNT_W-1:0]        count_o
);
  localparam int unsigned NWORDS = CNT_W / DATA_W;
  localparam int unsigned INT_W  = DATA_W - FRAC_W;

  logic [CNT_W-1:0]  count_q, count_d, base;
  logic [FRAC_W-1:0] frac_q, frac_d;
  logic [FRAC_W:0]   frac_sum;
  logic [CNT_W-1:0]  step;
  logic              any_wr, advance;

  assign any_wr   = |cnt_wr_i;
  assign advance  = en_i & tick_i & ~any_wr;
  assign frac_sum = {1'b0, frac_q} + {1'b0, scale_i[FRAC_W-1:0]};

  always_comb begin
    if (scale_en_i)
      step = CNT_W'(scale_i[DATA_W-1 -: INT_W]) + CNT_W'(frac_sum[FRAC_W]);
    else
      step = CNT_W'(1);
  end

  assign base = advance ? count_q + step : count_q;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    assign count_d[w*DATA_W +: DATA_W] = cnt_wr_i[w] ? wdata_i : base[w*DATA_W +: DATA_W];
  end

  always_comb begin
    frac_d = frac_q;
    if (any_wr) frac_d = '0;
    else if (advance && scale_en_i) frac_d = frac_sum[FRAC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      frac_q  <= '0;
    end else begin
      count_q <= count_d;
      frac_q  <= frac_d;
    end
  end

  assign count_o = count_q;

  p_halt_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !any_wr) |=> $stable(count_o));
  p_unit_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !scale_en_i && tick_i && !any_wr) |=> count_o == $past(count_o) + CNT_W'(1));
  p_frac_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_wr |=> frac_q == '0);
  p_sub_unit_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && scale_en_i && tick_i && !any_wr && scale_i[DATA_W-1 -: INT_W] == '0)
    |=> (count_o - $past(count_o)) <= CNT_W'(1));
endmodule

// File: rtl/scaled_sys_counter.sv
module scaled_sys_counter #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned FRAC_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_i,
  output logic [CNT_W-1:0]  count_o
);
  localparam int unsigned NWORDS = CNT_W / DATA_W;

  logic              en, scale_en;
  logic [DATA_W-1:0] scale;
  logic [NWORDS-1:0] cnt_wr;

  ssc_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .FRAC_W(FRAC_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .count_i    (count_o),
    .en_o       (en),
    .scale_en_o (scale_en),
    .scale_o    (scale),
    .cnt_wr_o   (cnt_wr),
    .rdata_o    (rdata_o)
  );

  ssc_core #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .FRAC_W(FRAC_W)
  ) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .en_i       (en),
    .scale_en_i (scale_en),
    .scale_i    (scale),
    .cnt_wr_i   (cnt_wr),
    .wdata_i    (wdata_i),
    .count_o    (count_o)
  );

  initial begin
    assert (CNT_W == 2 * DATA_W) else $error("count must span two data words");
    assert (FRAC_W < DATA_W) else $error("fraction must leave integer bits");
  end
endmodule

// File: tb/scaled_sys_counter_test.sv
`timescale 1ns/1ps
module scaled_sys_counter_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, tick_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [63:0] count_o;
  int n_chk = 0, n_bad = 0;

  always #5 clk_i = ~clk_i;

  scaled_sys_counter uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .tick_i(tick_i), .count_o(count_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = a;
    #1 d = rdata_o;
    req_i = 0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk_i);
    tick_i = 1;
    repeat (n) @(negedge clk_i);
    tick_i = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 count", count_o, 0);
    rd(5'h00, d); check("R1 ctrl", d, 0);
    rd(5'h04, d); check("R1 status", d, 1);
    rd(5'h10, d); check("R1 scale", d, 32'h0100_0000);
  endtask

  task automatic t_halt;
    ticks(100);
    check("R2 halted count", count_o, 0);
  endtask

  task automatic t_unit;
    logic [31:0] d;
    wr(5'h00, 1);
    rd(5'h04, d); check("R7 status running", d, 0);
    ticks(100);
    check("R3 100 ticks", count_o, 100);
    rd(5'h08, d); check("R3 low word", d, 100);
    rd(5'h0C, d); check("R3 high word", d, 0);
    @(negedge clk_i); tick_i = 1;
    @(negedge clk_i); tick_i = 0;
    repeat (5) @(negedge clk_i);
    @(negedge clk_i); tick_i = 1;
    @(negedge clk_i); tick_i = 0;
    check("R3 gapped ticks", count_o, 102);
  endtask

  task automatic t_scale;
    logic [31:0] d;
    wr(5'h00, 0);
    wr(5'h08, 100);
    wr(5'h10, 32'h0010_0000);
    wr(5'h00, 5);
    rd(5'h00, d); check("R4 ctrl both bits", d, 5);
    ticks(160);
    check("R5 sixteenth scale", count_o, 110);
    ticks(8);
    check("R5 half pending", count_o, 110);
    wr(5'h08, 0);
    ticks(8);
    check("R6 fraction cleared by write", count_o, 0);
    ticks(8);
    check("R5 carry after clear", count_o, 1);
    wr(5'h08, 0);
    wr(5'h10, 32'h0180_0000);
    ticks(4);
    check("R5 one and a half scale", count_o, 6);
    wr(5'h00, 4);
    rd(5'h04, d); check("R7 status halted", d, 1);
    ticks(10);
    check("R2 halted with scale on", count_o, 6);
  endtask

  task automatic t_words;
    logic [31:0] d;
    wr(5'h00, 0);
    wr(5'h0C, 32'h0000_0042);
    wr(5'h08, 32'hFFFF_FFFF);
    check("R6 high word kept", count_o, 64'h42_FFFF_FFFF);
    wr(5'h00, 1);
    ticks(1);
    check("R9 carry into high", count_o, 64'h43_0000_0000);
    rd(5'h0C, d); check("R9 high read", d, 32'h43);
    @(negedge clk_i); tick_i = 1;
    @(negedge clk_i); req_i = 1; we_i = 1; addr_i = 5'h08; wdata_i = 32'h55;
    @(negedge clk_i); req_i = 0; we_i = 0; tick_i = 0;
    check("R6 write beats tick", count_o, 64'h43_0000_0055);
  endtask

  task automatic t_undef;
    logic [31:0] d;
    wr(5'h00, 0);
    wr(5'h10, 32'h0200_0000);
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h09, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    rd(5'h14, d); check("R8 undefined read", d, 0);
    rd(5'h02, d); check("R8 unaligned read", d, 0);
    rd(5'h00, d); check("R8 ctrl untouched", d, 0);
    rd(5'h10, d); check("R8 scale untouched", d, 32'h0200_0000);
    check("R8 count untouched", count_o, 64'h43_0000_0055);
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, d); check("R4 ctrl mask", d, 5);
    ticks(3);
    check("R5 integer scale 2", count_o, 64'h43_0000_005B);
  endtask

  initial begin
    #200_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset;
    t_halt;
    t_unit;
    t_scale;
    t_words;
    t_undef;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule